// File: doc/BRIEF.md
# Clock Failure Guard with Safe-State Break

This block watches an external reference clock from a free-running internal clock. A 16-cycle window of the internal clock is measured repeatedly. If fewer than two external-clock edges arrive in one window while supervision is enabled, the block takes four actions:

- It moves the system clock mux over to the internal clock.
- It raises a sticky failure interrupt that has no mask.
- It asserts a break.
- It drives every PWM output to its programmed safe level, through hardware and with no software involved.

A dedicated break pin can also assert the break, with the same effect on the PWM outputs.

Software clears the failure and break latches with a one-cycle pulse on the clear input. After a fallback, the clock selection stays on the internal clock until the failure flag is clear and supervision sees a fresh rising edge of its enable. Supervision also stays halted until that fresh enable.

The external clock is sampled through a toggle flop that is synchronised by two flops into the internal domain. The external clock must therefore run at less than half the internal clock rate.

Top module: `clk_fail_guard`

## Requirements
- R1: While `mon_en` is low, no failure is ever detected, even if `clk_ext` stops.
- R2: While `mon_en` is high and the source is external, `fail_nmi` rises at the end of a 16-cycle window in which fewer than 2 synchronised external edges were seen. A running external clock never raises it, and a stopped one raises it within 40 internal cycles.
- R3: A detected failure sets `on_int` in the same cycle as `fail_nmi`, and from then on `sys_clk` follows `clk_int`. While `on_int` is low, `sys_clk` follows `clk_ext`.
- R4: `fail_nmi` has no mask. Once set, it stays high until a cycle in which `flag_clr` is sampled high.
- R5: `brk_out` is high whenever the failure flag, the latched pin break or the live `brk_pin` is high. While it is high, each bit of `pwm_out` equals the same bit of `pwm_safe`. Otherwise `pwm_out` equals `pwm_in`.
- R6: A high `brk_pin` is latched and keeps `brk_out` high until `flag_clr` is sampled while `brk_pin` is low. A pin break wins over a clear in the same cycle.
- R7: After a fallback, `on_int` returns low only at the first sampled rising edge of `mon_en` that comes after the failure flag is cleared. A clear pulse alone leaves `on_int` high, and supervision is halted until then.
- R8: After reset, `fail_nmi`, `brk_out` and `on_int` are low, and `pwm_out` equals `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Always-running internal clock |
| clk_ext | input | 1 | External reference clock under watch |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Supervision enable |
| flag_clr | input | 1 | One-cycle clear of failure and break latches |
| brk_pin | input | 1 | External break request, active high |
| pwm_in | input | NPWM | PWM levels from the timer |
| pwm_safe | input | NPWM | Programmed safe level of each PWM line |
| sys_clk | output | 1 | Selected system clock |
| fail_nmi | output | 1 | Sticky non-maskable failure interrupt |
| brk_out | output | 1 | Break state |
| on_int | output | 1 | High while the internal clock is selected |
| pwm_out | output | NPWM | PWM lines after the break gate |

## Verification
The bench targets the following corner cases:

- **Disabled supervision.** An external clock stops while supervision is off. A detector that ignores the enable would raise a false interrupt.
- **Slow but healthy clock.** A slow external clock that still gives two edges per window must not trip. An off-by-one threshold or window would make it trip.
- **Clear without re-enable.** A clear pulse with no fresh enable must leave the clock on the internal source. A design that ties the selection to the flag would hand the system back to a dead clock.
- **Break pin against clear.** A break pin held high across a clear must keep the break. A clear-first priority would briefly release the PWM lines from their safe levels.

// File: rtl/clk_fail_guard.sv
module clk_fail_guard #(
  parameter int NPWM      = 4,
  parameter int WIN       = 16,
  parameter int MIN_EDGES = 2
) (
  input  logic            clk_int,
  input  logic            clk_ext,
  input  logic            rst_n,
  input  logic            mon_en,
  input  logic            flag_clr,
  input  logic            brk_pin,
  input  logic [NPWM-1:0] pwm_in,
  input  logic [NPWM-1:0] pwm_safe,
  output logic            sys_clk,
  output logic            fail_nmi,
  output logic            brk_out,
  output logic            on_int,
  output logic [NPWM-1:0] pwm_out
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int EW = $clog2(MIN_EDGES + 1);

  logic          tog;
  logic [2:0]    sy;
  logic [WW-1:0] wcnt;
  logic [EW-1:0] ecnt, ecnt_nx;
  logic          en_d, fail_q, pin_q, sel_q;
  logic          run, hit, last, det;

  always_ff @(posedge clk_ext or negedge rst_n)
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], tog};

  assign hit     = sy[2] ^ sy[1];
  assign run     = mon_en & ~sel_q;
  assign last    = (wcnt == WW'(WIN - 1));
  assign ecnt_nx = (ecnt == EW'(MIN_EDGES)) ? ecnt : ecnt + EW'(hit);
  assign det     = run & last & (ecnt_nx < EW'(MIN_EDGES));

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (!run) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= last ? '0 : wcnt + 1'b1;
      ecnt <= last ? '0 : ecnt_nx;
    end

  always_ff @(posedge clk_int or negedge rst_n)
    if (!rst_n) begin
      en_d   <= 1'b0;
      fail_q <= 1'b0;
      pin_q  <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      en_d   <= mon_en;
      fail_q <= det | (fail_q & ~flag_clr);
      pin_q  <= brk_pin | (pin_q & ~flag_clr);
      if (det)                               sel_q <= 1'b1;
      else if (mon_en && !en_d && !fail_q)   sel_q <= 1'b0;
    end

  assign sys_clk  = sel_q ? clk_int : clk_ext;
  assign fail_nmi = fail_q;
  assign on_int   = sel_q;
  assign brk_out  = fail_q | pin_q | brk_pin;
  assign pwm_out  = brk_out ? pwm_safe : pwm_in;

  // R3
  fail_sel_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    fail_q |-> sel_q);
  // R4
  nmi_hold_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    fail_q |=> (fail_q || $past(flag_clr)));
  // R1
  en_req_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_q) |-> $past(mon_en));
  // R6
  pin_hold_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    brk_pin |=> pin_q);
  // R7
  back_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(sel_q) |-> ($past(mon_en) && !$past(fail_q)));
endmodule

// File: tb/test_clk_fail_guard.sv
`timescale 1ns/1ps
module test_clk_fail_guard;
  localparam int N = 4;
  logic clk_int = 0, clk_ext = 0, rst_n = 0;
  logic mon_en = 0, flag_clr = 0, brk_pin = 0;
  logic [N-1:0] pwm_in = '0, pwm_safe = 4'b0101, pwm_out;
  logic sys_clk, fail_nmi, brk_out, on_int;
  logic ext_run = 0;
  realtime ext_half = 7.5;
  int checks = 0, errors = 0, cyc = 0;
  logic m_fail = 0, m_sel = 0, m_pin = 0, prev_en = 0, live = 0;
  int stop_cnt = 0;
  logic late_seen = 0;

  clk_fail_guard #(.NPWM(N)) i_clk_fail_guard (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .mon_en(mon_en),
    .flag_clr(flag_clr), .brk_pin(brk_pin), .pwm_in(pwm_in), .pwm_safe(pwm_safe),
    .sys_clk(sys_clk), .fail_nmi(fail_nmi), .brk_out(brk_out), .on_int(on_int),
    .pwm_out(pwm_out));

  always #2.5 clk_int = ~clk_int;
  always begin
    #(ext_half);
    if (ext_run) clk_ext = ~clk_ext; else clk_ext = 1'b0;
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk_int) begin
    cyc++;
    if (rst_n) begin
      if (brk_pin) m_pin = 1; else if (flag_clr) m_pin = 0;
      if (flag_clr) m_fail = 0;
      if (mon_en && !prev_en && !m_fail) m_sel = 0;
      prev_en = mon_en;
      live = mon_en && !m_sel && !ext_run;
      if (live) stop_cnt++; else stop_cnt = 0;
      #1;
      if (fail_nmi && !m_fail && !m_sel && live) begin
        m_fail = 1; m_sel = 1;
      end
      if (stop_cnt > 40 && !m_fail && !late_seen) begin
        late_seen = 1;
        chk("R2 late detect", 1'b0, 1'b1);
      end
      chk("R4 fail_nmi", fail_nmi, m_fail);
      chk("R3 on_int", on_int, m_sel);
      chk("R5 brk_out", brk_out, m_fail | m_pin | brk_pin);
      chk("R5 pwm_out", pwm_out, (m_fail | m_pin | brk_pin) ? pwm_safe : pwm_in);
      chk("R3 sys_clk", sys_clk, m_sel ? clk_int : clk_ext);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk_int);
  endtask

  initial begin
    ext_run = 1;
    cycles(3);
    rst_n = 1;
    @(posedge clk_int); #1;
    // R8 reset state
    chk("R8 fail", fail_nmi, 1'b0);
    chk("R8 brk", brk_out, 1'b0);
    chk("R8 on_int", on_int, 1'b0);
    @(negedge clk_int);
    mon_en = 1; pwm_in = 4'b1010;
    cycles(100);
    // R2 slow but healthy clock must not trip
    ext_half = 15; cycles(100);
    chk("R2 slow ok", fail_nmi, 1'b0);
    ext_half = 7.5;
    // R1 stop with supervision off
    mon_en = 0; cycles(2); ext_run = 0; cycles(100);
    chk("R1 disabled", fail_nmi, 1'b0);
    ext_run = 1; cycles(10);
    mon_en = 1; cycles(40);
    ext_run = 0;
    for (int i = 0; i < 60 && !fail_nmi; i++) cycles(1);
    chk("R2 detected", fail_nmi, 1'b1);
    pwm_in = 4'b0011; cycles(5);
    chk("R5 safe", pwm_out, pwm_safe);
    flag_clr = 1; cycles(1); flag_clr = 0; cycles(2);
    chk("R4 cleared", fail_nmi, 1'b0);
    chk("R7 stays int", on_int, 1'b1);
    ext_run = 1; cycles(20);
    chk("R7 no redetect", fail_nmi, 1'b0);
    mon_en = 0; cycles(2); mon_en = 1; cycles(2);
    chk("R7 back ext", on_int, 1'b0);
    cycles(60);
    // R6 pin break
    brk_pin = 1; pwm_in = 4'b1100; cycles(1); brk_pin = 0; cycles(3);
    chk("R6 latched", brk_out, 1'b1);
    brk_pin = 1; flag_clr = 1; cycles(1); brk_pin = 0; flag_clr = 0; cycles(2);
    chk("R6 pin wins", brk_out, 1'b1);
    flag_clr = 1; cycles(1); flag_clr = 0; cycles(2);
    chk("R6 released", brk_out, 1'b0);
    chk("R5 pass", pwm_out, pwm_in);
    pwm_in = 4'b0110; pwm_safe = 4'b1001; cycles(3);
    brk_pin = 1; cycles(2); brk_pin = 0;
    flag_clr = 1; cycles(1); flag_clr = 0; cycles(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule